// File: doc/BRIEF.md
# Grouped polled interrupt controller

This block collects the interrupt events of a small 8-bit CPU subsystem. It drives two request lines into the CPU. One is a non-maskable request fed by a two-source group. The other is a maskable request fed by three groups. Two of those groups carry six serial-bus events each. The third carries a timer overflow, an external pin edge, a vertical-sync edge and a converter-done event. The CPU does the vectoring itself. This block only latches, masks, polls and clears.

Every source has a sticky request bit that latches whenever its trigger occurs, whether or not it is enabled. Every source also has an enable bit, and each request line is the OR of request AND enable over its sources. Software reads a group-level poll register to find which maskable groups have work pending, then reads the group's request register. It clears serviced requests by writing 1s to them. The three pin sources pass through a synchronizer, and each one has its own edge polarity select.

The register interface is a single-cycle write strobe with a local offset, and read data that follows the offset combinationally.

Top module: `intc_group_poll`

## Requirements
- R1: After reset, every request and enable bit is 0 and both request outputs are low. The edge-select register (offset 9) reads FFH.
- R2: A high event input in a cycle sets its request bit at that clock edge, even when the matching enable bit is 0. NMI group (offset 0): bit0 is auto-mute and bit1 is the external pin 0 edge. Bus groups (offsets 6 and 7): bit k is event input bit k. Misc group (offset 8): bit0 is the timer, bit1 the external pin 1 edge, bit2 the vertical-sync edge and bit3 converter-done.
- R3: Writing to a request offset (0, 6, 7 or 8) clears each request bit where the write data holds 1 and leaves the bits where it holds 0.
- R4: When a hardware set and a software clear hit the same request bit in the same cycle, the bit ends up set.
- R5: The group poll register (offset 1) reads bit g as 1 while any request in maskable group g is set (bit0 = offset 6, bit1 = offset 7, bit2 = offset 8). Writes to it have no effect.
- R6: Each pin goes through a two-flop synchronizer and a previous-value flop. A selected edge that is present at the pin before clock edge n sets the request at edge n+2. Edge-select bit 0 covers external pin 0, bit 1 external pin 1 and bit 2 the vertical-sync pin. A 1 selects the rising edge and a 0 the falling edge. Bits 7..3 always read 1.
- R7: The maskable output is the OR over groups 0 to 2 of request AND enable. The non-maskable output is the same OR over the NMI group alone. Both follow the registers with no extra delay.
- R8: The enable registers are at offset 2 (NMI group) and offsets 3 to 5 (groups 0 to 2). They read back what was written, limited to the bits the group implements. Offsets 10 to 15 read 0.
- R9: An enabled request that is never cleared keeps its output asserted for as long as no write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| ext0_pin | input | 1 | External pin 0 (non-maskable group) |
| ext1_pin | input | 1 | External pin 1 (misc group) |
| vsync_pin | input | 1 | Vertical-sync pin (misc group) |
| mute_evt | input | 1 | Auto-mute event pulse |
| bus0_evt | input | 6 | Serial-bus channel 0 event pulses |
| bus1_evt | input | 6 | Serial-bus channel 1 event pulses |
| adc_done | input | 1 | Converter-done pulse |
| timer_ovf | input | 1 | Timer overflow pulse |
| nmi_req | output | 1 | Non-maskable request to the CPU |
| irq_req | output | 1 | Maskable request to the CPU |

## Verification
A request bit that is lost, or that latches late, shows up on the very next read of its group offset or of the poll offset. If the source is enabled, it shows up in the same cycle on the matching request output. An enable bit or edge-select bit that holds a wrong value shows up later: either when a stored request fails to drive its output, or two cycles after a pin edge that fails to latch. The bench therefore compares both outputs and the read data at the current offset every cycle against a behavioural model, and rotates the offset so that every register is observed.

// File: rtl/intc_gp_pkg.sv
package intc_gp_pkg;
   // register offsets (local to the block)
   localparam int OFF_NMI    = 0;
   localparam int OFF_POLL   = 1;
   localparam int OFF_EN_NMI = 2;
   localparam int OFF_EN_G0  = 3;
   localparam int OFF_REQ_G0 = 6;
   localparam int OFF_SEL    = 9;

   localparam int NUM_GRP = 3;
   localparam int NMI_W   = 2;
   localparam int MISC_W  = 4;
   localparam int PIN_N   = 3;

   // pin indices
   localparam int PIN_EXT0 = 0;
   localparam int PIN_EXT1 = 1;
   localparam int PIN_VS   = 2;

   function automatic int grp_width(input int g, input int bus_w);
      return (g < 2) ? bus_w : MISC_W;
   endfunction
endpackage

// File: rtl/intc_gp_pin_edge.sv
module intc_gp_pin_edge #(
   parameter int N      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   input  logic [N-1:0] rise_sel_i,
   output logic [N-1:0] edge_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("intc_gp_pin_edge: STAGES must be at least 2");
   end

   for (genvar p = 0; p < N; p++) begin : g_pin
      logic [STAGES-1:0] chain;
      logic              prev;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
         end else begin
            chain <= {chain[STAGES-2:0], pin_i[p]};
            prev  <= chain[STAGES-1];
         end
      end
      assign edge_o[p] = rise_sel_i[p] ? (chain[STAGES-1] & ~prev)
                                       : (~chain[STAGES-1] & prev);
   end
endmodule

// File: rtl/intc_gp_req_bank.sv
module intc_gp_req_bank #(
   parameter int DATA_W = 8,
   parameter int ACT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_i,
   input  logic [DATA_W-1:0] clr_i,
   output logic [DATA_W-1:0] req_o
);
   localparam logic [DATA_W-1:0] MASK =
      (ACT_W >= DATA_W) ? '1 : DATA_W'((1 << ACT_W) - 1);

   if (ACT_W > DATA_W || ACT_W < 1) begin : g_bad_w
      $error("intc_gp_req_bank: ACT_W out of range");
   end

   logic [DATA_W-1:0] req_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= ((req_q & ~clr_i) | set_i) & MASK;
   end
   assign req_o = req_q;
endmodule

// File: rtl/intc_gp_cfg_reg.sv
module intc_gp_cfg_reg #(
   parameter int                DATA_W = 8,
   parameter int                ACT_W  = 8,
   parameter logic [DATA_W-1:0] RST    = '0,
   parameter bit                FILL   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [DATA_W-1:0] d_i,
   output logic [DATA_W-1:0] q_o
);
   localparam logic [DATA_W-1:0] MASK =
      (ACT_W >= DATA_W) ? '1 : DATA_W'((1 << ACT_W) - 1);

   if (ACT_W > DATA_W || ACT_W < 1) begin : g_bad_w
      $error("intc_gp_cfg_reg: ACT_W out of range");
   end

   logic [DATA_W-1:0] q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= RST & MASK;
      else if (we_i) q <= d_i & MASK;
   end

   if (FILL) begin : g_fill_one
      assign q_o = q | ~MASK;
   end else begin : g_fill_zero
      assign q_o = q;
   end
endmodule

// File: rtl/intc_group_poll.sv
module intc_group_poll
   import intc_gp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 4,
   parameter int BUS_EVT_W   = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic                 ext0_pin,
   input  logic                 ext1_pin,
   input  logic                 vsync_pin,
   input  logic                 mute_evt,
   input  logic [BUS_EVT_W-1:0] bus0_evt,
   input  logic [BUS_EVT_W-1:0] bus1_evt,
   input  logic                 adc_done,
   input  logic                 timer_ovf,
   output logic                 nmi_req,
   output logic                 irq_req
);
   if (BUS_EVT_W > DATA_W || MISC_W > DATA_W || PIN_N > DATA_W) begin : g_bad_w
      $error("intc_group_poll: a group is wider than DATA_W");
   end
   if ((1 << ADDR_W) <= OFF_SEL) begin : g_bad_a
      $error("intc_group_poll: ADDR_W too small for the register map");
   end

   localparam logic [ADDR_W-1:0] A_NMI    = ADDR_W'(OFF_NMI);
   localparam logic [ADDR_W-1:0] A_POLL   = ADDR_W'(OFF_POLL);
   localparam logic [ADDR_W-1:0] A_EN_NMI = ADDR_W'(OFF_EN_NMI);
   localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'(OFF_SEL);

   // pin edge detection
   logic [PIN_N-1:0]  pin_vec, pin_edge;
   logic [DATA_W-1:0] edge_sel;

   assign pin_vec[PIN_EXT0] = ext0_pin;
   assign pin_vec[PIN_EXT1] = ext1_pin;
   assign pin_vec[PIN_VS]   = vsync_pin;

   intc_gp_pin_edge #(.N(PIN_N), .STAGES(SYNC_STAGES)) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin_vec),
      .rise_sel_i (edge_sel[PIN_N-1:0]),
      .edge_o     (pin_edge)
   );

   intc_gp_cfg_reg #(.DATA_W(DATA_W), .ACT_W(PIN_N), .RST('1), .FILL(1'b1)) u_sel (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_en && addr == A_SEL),
      .d_i   (wdata),
      .q_o   (edge_sel)
   );

   // non-maskable group
   logic [DATA_W-1:0] nmi_set, nmi_clr, nmi_req_q, nmi_en_q;

   assign nmi_set = DATA_W'({pin_edge[PIN_EXT0], mute_evt});
   assign nmi_clr = (wr_en && addr == A_NMI) ? wdata : '0;

   intc_gp_req_bank #(.DATA_W(DATA_W), .ACT_W(NMI_W)) u_nmi_req (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (nmi_set),
      .clr_i (nmi_clr),
      .req_o (nmi_req_q)
   );

   intc_gp_cfg_reg #(.DATA_W(DATA_W), .ACT_W(NMI_W), .RST('0), .FILL(1'b0)) u_nmi_en (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_en && addr == A_EN_NMI),
      .d_i   (wdata),
      .q_o   (nmi_en_q)
   );

   // maskable groups
   logic [NUM_GRP-1:0][DATA_W-1:0] grp_set, grp_clr, grp_req, grp_en;
   logic [NUM_GRP-1:0]             grp_pend;

   assign grp_set[0] = DATA_W'(bus0_evt);
   assign grp_set[1] = DATA_W'(bus1_evt);
   assign grp_set[2] = DATA_W'({adc_done, pin_edge[PIN_VS], pin_edge[PIN_EXT1], timer_ovf});

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int                GW    = grp_width(g, BUS_EVT_W);
      localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(OFF_EN_G0 + g);
      localparam logic [ADDR_W-1:0] A_REQ = ADDR_W'(OFF_REQ_G0 + g);

      assign grp_clr[g] = (wr_en && addr == A_REQ) ? wdata : '0;

      intc_gp_req_bank #(.DATA_W(DATA_W), .ACT_W(GW)) u_req (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (grp_set[g]),
         .clr_i (grp_clr[g]),
         .req_o (grp_req[g])
      );

      intc_gp_cfg_reg #(.DATA_W(DATA_W), .ACT_W(GW), .RST('0), .FILL(1'b0)) u_en (
         .clk   (clk),
         .rst_n (rst_n),
         .we_i  (wr_en && addr == A_EN),
         .d_i   (wdata),
         .q_o   (grp_en[g])
      );

      assign grp_pend[g] = |grp_req[g];
   end

   // request outputs
   assign nmi_req = |(nmi_req_q & nmi_en_q);
   assign irq_req = |(grp_req & grp_en);

   // read mux
   always_comb begin
      rdata = '0;
      if (addr == A_NMI)    rdata = nmi_req_q;
      if (addr == A_POLL)   rdata = DATA_W'(grp_pend);
      if (addr == A_EN_NMI) rdata = nmi_en_q;
      if (addr == A_SEL)    rdata = edge_sel;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (addr == ADDR_W'(OFF_EN_G0 + g))  rdata = grp_en[g];
         if (addr == ADDR_W'(OFF_REQ_G0 + g)) rdata = grp_req[g];
      end
   end
endmodule

// File: rtl/intc_group_poll_chk.sv
module intc_group_poll_chk
   import intc_gp_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int BUS_EVT_W = 6
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             wr_en,
   input logic [ADDR_W-1:0]                addr,
   input logic [DATA_W-1:0]                wdata,
   input logic [DATA_W-1:0]                rdata,
   input logic [BUS_EVT_W-1:0]             bus0_evt,
   input logic                             nmi_req,
   input logic                             irq_req,
   input logic [NUM_GRP-1:0][DATA_W-1:0]   grp_req,
   input logic [NUM_GRP-1:0][DATA_W-1:0]   grp_en
);
   // R1: held reset keeps outputs and requests clear
   p_reset_quiet_r1: assert property (@(posedge clk)
      (!rst_n && $past(!rst_n)) |-> (!irq_req && !nmi_req && grp_req == '0));

   // R2: an event latches regardless of enables
   p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus0_evt != '0) |=>
      ((grp_req[0][BUS_EVT_W-1:0] & $past(bus0_evt)) == $past(bus0_evt)));

   // R3: write-one clear
   p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_REQ_G0) && bus0_evt == '0) |=>
      ((grp_req[0] & $past(wdata)) == '0));

   // R4: set beats clear
   p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_REQ_G0) && (bus0_evt & wdata[BUS_EVT_W-1:0]) != '0) |=>
      ((grp_req[0][BUS_EVT_W-1:0] & $past(bus0_evt)) == $past(bus0_evt)));

   // R5: group poll summarises pending groups
   p_poll_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(OFF_POLL)) |->
      (rdata == DATA_W'({|grp_req[2], |grp_req[1], |grp_req[0]})));

   // R7: nothing enabled means no maskable request
   p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_en == '0) |-> !irq_req);

   // R8: enable write is stored
   p_en_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == ADDR_W'(OFF_EN_G0)) |=>
      (grp_en[0][BUS_EVT_W-1:0] == $past(wdata[BUS_EVT_W-1:0])));

   // R9: an uncleared request stays asserted
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && !wr_en) |=> irq_req);
endmodule

bind intc_group_poll intc_group_poll_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BUS_EVT_W(BUS_EVT_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .bus0_evt (bus0_evt),
   .nmi_req  (nmi_req),
   .irq_req  (irq_req),
   .grp_req  (grp_req),
   .grp_en   (grp_en)
);

// File: tb/intc_group_poll_tb.sv
`timescale 1ns/1ps
module intc_group_poll_tb;
   localparam int HALF = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [3:0] addr = 4'd9;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       ext0_pin = 1'b0, ext1_pin = 1'b0, vsync_pin = 1'b0;
   logic       mute_evt = 1'b0, adc_done = 1'b0, timer_ovf = 1'b0;
   logic [5:0] bus0_evt = '0, bus1_evt = '0;
   logic       nmi_req, irq_req;

   always #HALF clk = ~clk;

   intc_group_poll u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ext0_pin(ext0_pin), .ext1_pin(ext1_pin),
      .vsync_pin(vsync_pin), .mute_evt(mute_evt), .bus0_evt(bus0_evt),
      .bus1_evt(bus1_evt), .adc_done(adc_done), .timer_ovf(timer_ovf),
      .nmi_req(nmi_req), .irq_req(irq_req)
   );

   int    n_chk = 0, n_fail = 0;
   string phase = "R1 reset";
   bit    started = 0, done = 0;

   // behavioural reference: index 0 = NMI group, 1..3 = maskable groups 0..2
   int m_req[4], m_en[4], m_sel;
   int hist[3][3];  // hist[pin][k] = pin value sampled k+1 edges ago

   function automatic int gmask(input int i);
      return (i == 0) ? 3 : (i == 3) ? 15 : 63;
   endfunction

   function automatic int m_read(input int a);
      case (a)
         0: return m_req[0];
         1: return ((m_req[1] != 0) ? 1 : 0) | ((m_req[2] != 0) ? 2 : 0) | ((m_req[3] != 0) ? 4 : 0);
         2, 3, 4, 5: return m_en[a-2];
         6, 7, 8: return m_req[a-5];
         9: return 8'hF8 | m_sel;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 4; i++) begin m_req[i] = 0; m_en[i] = 0; end
         m_sel = 7;
         for (int p = 0; p < 3; p++) for (int k = 0; k < 3; k++) hist[p][k] = 0;
      end else begin
         int e[3];
         int s[4];
         int c[4];
         int pins[3];
         pins[0] = int'(ext0_pin); pins[1] = int'(ext1_pin); pins[2] = int'(vsync_pin);
         for (int p = 0; p < 3; p++) begin
            if ((m_sel >> p) & 1) e[p] = (hist[p][1] == 1 && hist[p][2] == 0) ? 1 : 0;
            else                  e[p] = (hist[p][1] == 0 && hist[p][2] == 1) ? 1 : 0;
         end
         s[0] = int'(mute_evt) | (e[0] << 1);
         s[1] = int'(bus0_evt);
         s[2] = int'(bus1_evt);
         s[3] = int'(timer_ovf) | (e[1] << 1) | (e[2] << 2) | (int'(adc_done) << 3);
         for (int i = 0; i < 4; i++) c[i] = 0;
         if (wr_en) begin
            if (addr == 0) c[0] = int'(wdata);
            if (addr >= 6 && addr <= 8) c[int'(addr) - 5] = int'(wdata);
         end
         for (int i = 0; i < 4; i++) m_req[i] = ((m_req[i] & ~c[i]) | s[i]) & gmask(i);
         if (wr_en && addr >= 2 && addr <= 5) m_en[int'(addr) - 2] = int'(wdata) & gmask(int'(addr) - 2);
         if (wr_en && addr == 9) m_sel = int'(wdata) & 7;
         for (int p = 0; p < 3; p++) begin
            hist[p][2] = hist[p][1]; hist[p][1] = hist[p][0]; hist[p][0] = pins[p];
         end
      end
      started = 1;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s [%s] actual=%0h expected=%0h at %0t", tag, phase, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (started && !done) begin
         int ei, en;
         string t;
         ei = 0; en = 0;
         for (int i = 1; i < 4; i++) if ((m_req[i] & m_en[i]) != 0) ei = 1;
         if ((m_req[0] & m_en[0]) != 0) en = 1;
         case (addr)
            4'd0:                t = "R2 nmi group requests";
            4'd1:                t = "R5 group poll";
            4'd2, 4'd3, 4'd4, 4'd5: t = "R8 enable readback";
            4'd6, 4'd7, 4'd8:    t = "R3 group requests";
            4'd9:                t = "R6 edge select";
            default:             t = "R8 unmapped offset";
         endcase
         if (!rst_n) t = {"R1 ", t};
         chk("R7 irq_req", {31'd0, irq_req}, ei);
         chk("R7 nmi_req", {31'd0, nmi_req}, en);
         chk(t, {24'd0, rdata}, m_read(int'(addr)));
      end
   end

   task automatic step(input logic we, input logic [3:0] a, input logic [7:0] d,
                       input logic [5:0] b0, input logic [5:0] b1,
                       input logic [3:0] misc);  // misc = {adc, timer, mute, unused}
      @(negedge clk); #2;
      wr_en = we; addr = a; wdata = d; bus0_evt = b0; bus1_evt = b1;
      adc_done = misc[3]; timer_ovf = misc[2]; mute_evt = misc[1];
   endtask

   task automatic rd(input logic [3:0] a);
      step(1'b0, a, 8'h00, 6'h0, 6'h0, 4'h0);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      step(1'b1, a, d, 6'h0, 6'h0, 4'h0);
   endtask

   task automatic finish_run();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(HALF * 2 * 200000);
      n_fail++;
      $display("FAIL watchdog expired [%s]", phase);
      finish_run();
   end

   initial begin
      logic [31:0] lfsr;
      // R1: reset state
      repeat (3) rd(4'd9);
      @(negedge clk); #2; rst_n = 1'b1;
      for (int a = 0; a < 16; a++) rd(4'(a));

      // R2: events latch with everything disabled
      phase = "R2 latch while disabled";
      step(1'b0, 4'd6, 8'h00, 6'h3F, 6'h2A, 4'b1110);
      rd(4'd0); rd(4'd6); rd(4'd7); rd(4'd8); rd(4'd1);

      // R8 / R7: enables read back and drive outputs
      phase = "R8 R7 enables";
      wr(4'd2, 8'hFF); rd(4'd2);
      wr(4'd3, 8'hFF); rd(4'd3);
      wr(4'd4, 8'h01); rd(4'd4);
      wr(4'd5, 8'hFF); rd(4'd5);

      // R9: no clear, outputs held
      phase = "R9 hold";
      repeat (8) rd(4'd1);

      // R3: write-one clear, zero bits keep
      phase = "R3 clear";
      wr(4'd6, 8'h00); rd(4'd6);
      wr(4'd6, 8'h05); rd(4'd6);
      wr(4'd7, 8'h2A); rd(4'd7);
      wr(4'd8, 8'h0F); rd(4'd8);
      wr(4'd0, 8'h03); rd(4'd0);

      // R5: poll register ignores writes, clears when group empties
      phase = "R5 poll";
      wr(4'd1, 8'hFF); rd(4'd1);
      wr(4'd6, 8'h3A); rd(4'd1);
      step(1'b0, 4'd1, 8'h00, 6'h04, 6'h0, 4'h0); rd(4'd1);
      wr(4'd6, 8'h3F); rd(4'd1);

      // R6: pin edges, rising then falling
      phase = "R6 rising";
      ext0_pin = 1'b1; ext1_pin = 1'b1; vsync_pin = 1'b1;
      repeat (5) rd(4'd8);
      rd(4'd0);
      wr(4'd8, 8'h0F); wr(4'd0, 8'h03);
      ext0_pin = 1'b0; ext1_pin = 1'b0; vsync_pin = 1'b0;
      repeat (5) rd(4'd8);
      phase = "R6 falling";
      wr(4'd9, 8'h00); rd(4'd9);
      ext0_pin = 1'b1; vsync_pin = 1'b1;
      repeat (5) rd(4'd8);
      ext0_pin = 1'b0; vsync_pin = 1'b0;
      repeat (5) rd(4'd8);
      rd(4'd0);
      wr(4'd9, 8'hFF);

      // R4: set and clear in the same cycle
      phase = "R4 set beats clear";
      step(1'b1, 4'd6, 8'h3F, 6'h3F, 6'h0, 4'h0); rd(4'd6);
      step(1'b1, 4'd8, 8'h0F, 6'h0, 6'h0, 4'b1100); rd(4'd8);
      step(1'b1, 4'd0, 8'h03, 6'h0, 6'h0, 4'b0010); rd(4'd0);

      // mixed traffic
      phase = "R2 R3 R5 R6 R7 mixed";
      lfsr = 32'hACE1_2345;
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         lfsr = lfsr ^ (lfsr << 13) ^ (lfsr >> 7);
         if (lfsr[3:0] == 4'd0) ext0_pin = ~ext0_pin;
         if (lfsr[7:4] == 4'd1) ext1_pin = ~ext1_pin;
         if (lfsr[11:8] == 4'd2) vsync_pin = ~vsync_pin;
         step(lfsr[12] & lfsr[13], lfsr[19:16], lfsr[27:20],
              lfsr[5:0] & lfsr[25:20] & {6{lfsr[14]}},
              lfsr[11:6] & lfsr[31:26] & {6{lfsr[15]}},
              {lfsr[28] & lfsr[29], lfsr[30] & lfsr[31], lfsr[29] & lfsr[30] & lfsr[31], 1'b0});
      end
      rd(4'd1);
      finish_run();
   end
endmodule